// File: doc/BRIEF.md
# Raster Timing Generator with CPU Status Word

This block produces the scan timing for one display. A pixel-clock enable advances a horizontal position counter. Each time a line finishes, a vertical position counter advances. From these two positions the block decodes the horizontal and vertical sync pulses, the active-video flags and a combined blanking flag. It also gives a one-cycle pulse at the end of each frame for downstream logic.

A processor polls the raster through a 16-bit read-only status word. The upper byte reports the sync and blank conditions as active-low bits. The lower byte reports a line number that runs 15 lines ahead of the real scan line, wraps at the frame height, and is clamped to all ones once it passes 255. The word is captured into a register when the read strobe is high, so a polling processor sees a coherent snapshot and never a word that changes partway through a bus cycle.

Top module: `scan_status_gen`

## Requirements
- R1: The horizontal position counts 0 to 431 and then wraps to 0. It advances only on clock edges where `pixEn` is high. The vertical position counts 0 to 261 and advances only when the horizontal position wraps.
- R2: `hActive` is high while the horizontal position is below 320. `vActive` is high while the vertical position is below 240.
- R3: `hSync` is high for horizontal positions 352 to 383 inclusive.
- R4: `vSync` is high for vertical positions 245 to 247 inclusive.
- R5: `blank` is high whenever the horizontal position is 320 or more, or the vertical position is 240 or more.
- R6: `frameEnd` is high for exactly one clock cycle: the cycle that follows the edge where the counters advance from (431, 261) to (0, 0).
- R7: On a clock edge with `rdStb` high, `statusQ` loads the status word built from the positions held before that edge. Without the strobe, `statusQ` holds its value. Reset sets it to 0xFFFF.
- R8: Bits of the status word: bit 15 is the inverse of `hSync`, bit 14 is the inverse of `vSync`, bit 8 is the inverse of `blank`, and bits 13 to 9 always read 1.
- R9: Bits 7 to 0 of the status word hold L = (vertical position + 15) mod 262 when L < 256. When L is 256 or more, they read 0xFF.
- R10: While reset is active, both positions are 0 and `frameEnd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixEn | input | 1 | Pixel-clock enable; the horizontal position advances when it is high |
| rdStb | input | 1 | Read strobe; captures the status word |
| hPos | output | 9 | Current horizontal position |
| vPos | output | 9 | Current vertical position |
| hSync | output | 1 | Horizontal sync, active high |
| vSync | output | 1 | Vertical sync, active high |
| hActive | output | 1 | Horizontal position is inside the visible area |
| vActive | output | 1 | Vertical position is inside the visible area |
| blank | output | 1 | Either position is outside the visible area |
| frameEnd | output | 1 | One-cycle pulse after the wrap into line 0 |
| statusQ | output | 16 | Captured status word |

## Verification
A status capture can land on the same edge as a line wrap or a frame wrap. In that case the captured word must reflect the position held before the edge, not the position after it. The bench raises the read strobe at the last pixel of every line, including the final line of the frame. Its scoreboard predicts each word from its own model of the position seen at the strobe edge, and compares it one cycle later. Gaps in `pixEn` at the start of the run also place strobes on edges where the counters hold, so capture is checked separately from advance.

// File: rtl/scan_pkg.sv
package scan_pkg;
  // strobes passed from the counter control to the decode datapath
  typedef struct packed {
    logic capture;    // latch the status word this edge
    logic frameWrap;  // counters leave the final position this edge
  } scanStrobe_t;
endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
#(
  parameter int H_TOTAL = 432,
  parameter int V_TOTAL = 262,
  parameter int H_W     = $clog2(H_TOTAL),
  parameter int V_W     = $clog2(V_TOTAL)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           pixEn,
  input  logic           rdStb,
  output logic [H_W-1:0] hCnt,
  output logic [V_W-1:0] vCnt,
  output scanStrobe_t    stb
);
  localparam logic [H_W-1:0] H_LAST = H_W'(H_TOTAL - 1);
  localparam logic [V_W-1:0] V_LAST = V_W'(V_TOTAL - 1);

  logic hLast, vLast, lineWrap;

  assign hLast    = (hCnt == H_LAST);
  assign vLast    = (vCnt == V_LAST);
  assign lineWrap = pixEn && hLast;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hCnt <= '0;
    end else if (pixEn) begin
      hCnt <= hLast ? '0 : hCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vCnt <= '0;
    end else if (lineWrap) begin
      vCnt <= vLast ? '0 : vCnt + 1'b1;
    end
  end

  always_comb begin
    stb.capture   = rdStb;
    stb.frameWrap = lineWrap && vLast;
  end

  // R1: positions never leave their ranges
  p_hrange_r1: assert property (@(posedge clk) disable iff (!rstN) hCnt <= H_LAST);
  p_vrange_r1: assert property (@(posedge clk) disable iff (!rstN) vCnt <= V_LAST);
  // R1: no enable, no movement
  p_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !pixEn |=> $stable(hCnt) && $stable(vCnt));
  // R1: the last pixel wraps to zero
  p_hwrap_r1: assert property (@(posedge clk) disable iff (!rstN)
    (pixEn && hCnt == H_LAST) |=> hCnt == '0);
endmodule

// File: rtl/scan_datapath.sv
module scan_datapath
  import scan_pkg::*;
#(
  parameter int H_TOTAL     = 432,
  parameter int H_ACTIVE    = 320,
  parameter int HS_START    = 352,
  parameter int HS_LEN      = 32,
  parameter int V_TOTAL     = 262,
  parameter int V_ACTIVE    = 240,
  parameter int VS_START    = 245,
  parameter int VS_LEN      = 3,
  parameter int LINE_OFFSET = 15,
  parameter int H_W         = $clog2(H_TOTAL),
  parameter int V_W         = $clog2(V_TOTAL)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [H_W-1:0] hCnt,
  input  logic [V_W-1:0] vCnt,
  input  scanStrobe_t    stb,
  output logic           hSync,
  output logic           vSync,
  output logic           hActive,
  output logic           vActive,
  output logic           blank,
  output logic           frameEnd,
  output logic [15:0]    statusQ
);
  localparam int S_W = V_W + 1;
  localparam logic [H_W-1:0] H_ACT_C  = H_W'(H_ACTIVE);
  localparam logic [H_W-1:0] HS_BEG_C = H_W'(HS_START);
  localparam logic [H_W-1:0] HS_END_C = H_W'(HS_START + HS_LEN);
  localparam logic [V_W-1:0] V_ACT_C  = V_W'(V_ACTIVE);
  localparam logic [V_W-1:0] VS_BEG_C = V_W'(VS_START);
  localparam logic [V_W-1:0] VS_END_C = V_W'(VS_START + VS_LEN);
  localparam logic [S_W-1:0] OFFS_C   = S_W'(LINE_OFFSET);
  localparam logic [S_W-1:0] VTOT_C   = S_W'(V_TOTAL);
  localparam logic [S_W-1:0] CLAMP_C  = S_W'(256);

  logic [S_W-1:0] lineSum, lineWrapd;
  logic [7:0]     lineByte;
  logic [15:0]    liveWord;

  // position decode
  always_comb begin
    hActive = (hCnt < H_ACT_C);
    vActive = (vCnt < V_ACT_C);
    hSync   = (hCnt >= HS_BEG_C) && (hCnt < HS_END_C);
    vSync   = (vCnt >= VS_BEG_C) && (vCnt < VS_END_C);
    blank   = !(hActive && vActive);
  end

  // offset line number, wrapped at frame height, clamped to one byte
  always_comb begin
    lineSum   = {1'b0, vCnt} + OFFS_C;
    lineWrapd = (lineSum >= VTOT_C) ? lineSum - VTOT_C : lineSum;
    lineByte  = (lineWrapd < CLAMP_C) ? lineWrapd[7:0] : 8'hFF;
  end

  always_comb begin
    liveWord       = 16'hFF00;
    liveWord[15]   = !hSync;
    liveWord[14]   = !vSync;
    liveWord[8]    = !blank;
    liveWord[7:0]  = lineByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= 16'hFFFF;
    end else if (stb.capture) begin
      statusQ <= liveWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) frameEnd <= 1'b0;
    else       frameEnd <= stb.frameWrap;
  end

  // R7: no strobe, no change
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !stb.capture |=> $stable(statusQ));
  // R8: filler bits stay high in every captured word
  p_filler_r8: assert property (@(posedge clk) disable iff (!rstN)
    statusQ[13:9] == 5'h1F);
  // R6: the frame pulse lasts one cycle
  p_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |=> !frameEnd);
  // R6: the pulse follows the wrap into the origin
  p_origin_r6: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |-> (hCnt == '0 && vCnt == '0));
  // R4: vertical sync lies inside the vertical blank
  p_vsblank_r4: assert property (@(posedge clk) disable iff (!rstN)
    vSync |-> blank);
endmodule

// File: rtl/scan_status_gen.sv
module scan_status_gen
  import scan_pkg::*;
#(
  parameter int H_TOTAL     = 432,
  parameter int H_ACTIVE    = 320,
  parameter int HS_START    = 352,
  parameter int HS_LEN      = 32,
  parameter int V_TOTAL     = 262,
  parameter int V_ACTIVE    = 240,
  parameter int VS_START    = 245,
  parameter int VS_LEN      = 3,
  parameter int LINE_OFFSET = 15,
  localparam int H_W        = $clog2(H_TOTAL),
  localparam int V_W        = $clog2(V_TOTAL)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           pixEn,
  input  logic           rdStb,
  output logic [H_W-1:0] hPos,
  output logic [V_W-1:0] vPos,
  output logic           hSync,
  output logic           vSync,
  output logic           hActive,
  output logic           vActive,
  output logic           blank,
  output logic           frameEnd,
  output logic [15:0]    statusQ
);
  scanStrobe_t stb;

  scan_ctrl #(
    .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .H_W(H_W), .V_W(V_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .pixEn(pixEn), .rdStb(rdStb),
    .hCnt(hPos), .vCnt(vPos), .stb(stb)
  );

  scan_datapath #(
    .H_TOTAL(H_TOTAL), .H_ACTIVE(H_ACTIVE), .HS_START(HS_START), .HS_LEN(HS_LEN),
    .V_TOTAL(V_TOTAL), .V_ACTIVE(V_ACTIVE), .VS_START(VS_START), .VS_LEN(VS_LEN),
    .LINE_OFFSET(LINE_OFFSET), .H_W(H_W), .V_W(V_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .hCnt(hPos), .vCnt(vPos), .stb(stb),
    .hSync(hSync), .vSync(vSync), .hActive(hActive), .vActive(vActive),
    .blank(blank), .frameEnd(frameEnd), .statusQ(statusQ)
  );
endmodule

// File: tb/scan_status_gen_bench.sv
module scan_status_gen_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pixEn = 1'b0;
  logic rdStb = 1'b0;
  logic [8:0] hPos, vPos;
  logic hSync, vSync, hActive, vActive, blank, frameEnd;
  logic [15:0] statusQ;

  int nCmp = 0;
  int nBad = 0;
  bit done = 1'b0;

  // bench model of the raster position
  int mh = 0, mv = 0;
  bit mFe = 1'b0;
  bit pending = 1'b0;
  logic [15:0] expQ[$];

  always #10 clk = ~clk;

  scan_status_gen u_scan_status_gen (
    .clk(clk), .rstN(rstN), .pixEn(pixEn), .rdStb(rdStb),
    .hPos(hPos), .vPos(vPos), .hSync(hSync), .vSync(vSync),
    .hActive(hActive), .vActive(vActive), .blank(blank),
    .frameEnd(frameEnd), .statusQ(statusQ)
  );

  function automatic logic [15:0] predict(int h, int v);
    logic [15:0] w;
    int ln;
    w = 16'hFF00;
    if (h >= 352 && h < 384) w[15] = 1'b0;
    if (v >= 245 && v < 248) w[14] = 1'b0;
    if (h >= 320 || v >= 240) w[8] = 1'b0;
    ln = v + 15;
    if (ln >= 262) ln = ln - 262;
    w[7:0] = (ln < 256) ? ln[7:0] : 8'hFF;
    return w;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s at h=%0d v=%0d: actual %h expected %h", req, mh, mv, act, exp);
    end
  endtask

  // model advance, R1 and R6 reference
  always @(posedge clk) begin
    if (!rstN) begin
      mh <= 0; mv <= 0; mFe <= 1'b0; pending <= 1'b0;
    end else begin
      pending <= rdStb;
      mFe <= pixEn && mh == 431 && mv == 261;
      if (pixEn) begin
        if (mh == 431) begin
          mh <= 0;
          mv <= (mv == 261) ? 0 : mv + 1;
        end else mh <= mh + 1;
      end
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R1 hPos", 32'(hPos), 32'(mh));
      check("R1 vPos", 32'(vPos), 32'(mv));
      check("R2 hActive", 32'(hActive), 32'(mh < 320));
      check("R2 vActive", 32'(vActive), 32'(mv < 240));
      check("R3 hSync", 32'(hSync), 32'(mh >= 352 && mh < 384));
      check("R4 vSync", 32'(vSync), 32'(mv >= 245 && mv < 248));
      check("R5 blank", 32'(blank), 32'(mh >= 320 || mv >= 240));
      check("R6 frameEnd", 32'(frameEnd), 32'(mFe));
      if (pending) begin
        if (expQ.size() == 0) check("R7 queue", 32'd1, 32'd0);
        else check("R7 R8 R9 statusQ", 32'(statusQ), 32'(expQ.pop_front()));
      end
    end
  end

  // driver
  initial begin
    repeat (4) @(negedge clk);
    // R10 reset state
    check("R10 hPos", 32'(hPos), 32'd0);
    check("R10 vPos", 32'(vPos), 32'd0);
    check("R10 frameEnd", 32'(frameEnd), 32'd0);
    check("R7 reset statusQ", 32'(statusQ), 32'hFFFF);
    rstN = 1'b1;
    for (int i = 0; i < 113184 + 4000; i++) begin
      pixEn = (i < 4000) ? (i % 3 != 0) : 1'b1;
      // strobe in active area, in sync, and on each line's last pixel
      rdStb = (mh == 100 || mh == 330 || mh == 360 || mh == 431 || (i < 4000 && i % 7 == 0));
      if (rdStb) expQ.push_back(predict(mh, mv));
      @(negedge clk);
    end
    rdStb = 1'b0;
    pixEn = 1'b0;
    @(negedge clk);
    // R7 hold: status unchanged without strobe
    begin
      logic [15:0] snap;
      snap = statusQ;
      repeat (3) @(negedge clk);
      check("R7 hold", 32'(statusQ), 32'(snap));
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nCmp++;
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule